// File: doc/BRIEF.md
# Shared-Pool Packet Dispatcher with Per-Engine Buffers

This block sits between a line-rate ingress packet stream and a set of parallel processing engines. Every arriving packet first lands in one shared pool. Whole packets are then copied, one at a time, into the single-packet buffer of an idle engine. When several engines are idle, the lowest-numbered one is served first. An engine reads its packet from its buffer, writes the result back in place and signals completion together with the result length.

An egress scheduler visits the engines that hold finished results in rotating order. It sends each result out as one unbroken packet. When the last word of a result has left, the scheduler frees that engine's buffer and pulses the engine's completion interrupt. The dispatcher then refills the freed buffer with the oldest complete packet waiting in the pool.

The pool holds as many words as all engine buffers together, which covers the case where every engine is busy. There is no backpressure on the ingress side. A packet that finds less than one maximum-length packet of free space when it starts is discarded whole, and a drop counter counts it.

Top module: `pkt_dispatch`

## Requirements
- R1: After reset, `eng_busy`, `eng_irq`, `out_valid` and `drop_count` are all zero.
- R2: The pool holds NUM_ENG*MAX_WORDS words. At each start-of-packet word, the packet is accepted only if the free pool space is at least MAX_WORDS words. Otherwise every word of that packet is discarded and `drop_count` rises by exactly one.
- R3: Only a packet whose end word has arrived is moved to an engine, and it is moved entirely into one engine buffer. After the move, that engine's `eng_busy` bit is 1 and its `eng_len` field (bits [e*LW +: LW]) equals the packet's word count.
- R4: When a complete packet is waiting and several engines are free, the free engine with the lowest index receives it.
- R5: Packets leave the pool in the order in which they arrived.
- R6: While `eng_busy[e]` is 1, engine e reads word a of its buffer combinationally on `eng_rd_data` by driving `eng_rd_addr`. It writes results with `eng_we`, `eng_wr_addr` and `eng_wr_data`, and ends with a one-cycle `eng_done` carrying the result length in `eng_done_len`. `eng_busy` then falls, and no result leaves before its `eng_done`.
- R7: Among engines with finished results, egress serves first the one that comes next after the most recently served engine, wrapping from NUM_ENG-1 to 0. Each result leaves on consecutive cycles, with `out_sop` on word 0 and `out_eop` on the last word.
- R8: In the cycle after a result's `out_eop`, exactly the bit of `eng_irq` for the engine that held it is 1, for one cycle. That engine's buffer is then free to be refilled from the pool.
- R9: Every accepted packet leaves exactly once, as the engine's result, with its length intact. Accepted plus dropped packets equals sent packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Ingress word valid |
| in_sop | input | 1 | Ingress first word of packet |
| in_eop | input | 1 | Ingress last word of packet |
| in_data | input | DW | Ingress data word |
| eng_busy | output | NUM_ENG | Engine e owns a loaded packet |
| eng_len | output | NUM_ENG*LW | Loaded packet length per engine, in words |
| eng_rd_addr | input | NUM_ENG*AW | Engine buffer read address |
| eng_rd_data | output | NUM_ENG*DW | Engine buffer read data (combinational) |
| eng_we | input | NUM_ENG | Engine buffer write enable |
| eng_wr_addr | input | NUM_ENG*AW | Engine buffer write address |
| eng_wr_data | input | NUM_ENG*DW | Engine buffer write data |
| eng_done | input | NUM_ENG | Engine result complete (one cycle) |
| eng_done_len | input | NUM_ENG*LW | Result length in words |
| eng_irq | output | NUM_ENG | Completion interrupt: result has left |
| out_valid | output | 1 | Egress word valid |
| out_sop | output | 1 | Egress first word |
| out_eop | output | 1 | Egress last word |
| out_data | output | DW | Egress data word |
| drop_count | output | CNT_W | Number of discarded packets |

## Verification
A directed phase holds all engines, fills every engine buffer with packets of different lengths, and then fills the pool exactly to its limit. The accepted packet at the limit and the single-word packet dropped just past it separate a correct space check from an off-by-one. Releasing the engines at the same moment, and later releasing one engine alone before the others, tells true rotating egress order apart from fixed priority. It also shows that refills follow pool arrival order. A constrained-random phase then mixes random lengths, gaps and engine latencies, so that pool-full drops and concurrent refills interleave. In that phase every result is checked word by word against its tag, duplicates are caught, and the accounting of accepted and dropped packets is checked.

// File: rtl/pkt_disp_pkg.sv
package pkt_disp_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_FILL = 2'd1,
    SLOT_WORK = 2'd2,
    SLOT_SEND = 2'd3
  } slot_state_e;
endpackage

// File: rtl/pkt_pool.sv
module pkt_pool #(
  parameter int DW        = 64,
  parameter int DEPTH     = 32,
  parameter int MAX_WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [DW-1:0] in_data,
  input  logic          pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_eop,
  output logic          pkt_avail,
  output logic          drop_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem_d [DEPTH];
  logic          mem_e [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [OW-1:0] occ, occ_n, pkts, pkts_n;
  logic          acc_q, acc_n, room_ok, take;

  // room for a worst-case packet is reserved at its first word
  assign room_ok    = (OW'(DEPTH) - occ) >= OW'(MAX_WORDS);
  assign take       = in_valid && (in_sop ? room_ok : acc_q);
  assign drop_pulse = in_valid && in_sop && !room_ok;
  assign rd_data    = mem_d[rd_ptr];
  assign rd_eop     = mem_e[rd_ptr];
  assign pkt_avail  = (pkts != '0);

  always_comb begin
    acc_n = acc_q;
    if (in_valid) begin
      if (in_sop) acc_n = room_ok;
      if (in_eop) acc_n = 1'b0;
    end
    wr_ptr_n = wr_ptr;
    if (take) wr_ptr_n = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
    rd_ptr_n = rd_ptr;
    if (pop) rd_ptr_n = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    occ_n  = occ + OW'(take) - OW'(pop);
    pkts_n = pkts + OW'(take && in_eop) - OW'(pop && rd_eop);
  end

  always_ff @(posedge clk) begin
    if (take) begin
      mem_d[wr_ptr] <= in_data;
      mem_e[wr_ptr] <= in_eop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
      pkts   <= '0;
    end else begin
      acc_q  <= acc_n;
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      occ    <= occ_n;
      pkts   <= pkts_n;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (occ < OW'(DEPTH)));
  assert_whole_packet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (pkts != '0));
endmodule

// File: rtl/pkt_slot.sv
module pkt_slot
  import pkt_disp_pkg::*;
#(
  parameter int DW        = 64,
  parameter int MAX_WORDS = 8,
  localparam int AW       = $clog2(MAX_WORDS),
  localparam int LW       = $clog2(MAX_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic          fill_last,
  input  logic [AW-1:0] eng_rd_addr,
  output logic [DW-1:0] eng_rd_data,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_wr_addr,
  input  logic [DW-1:0] eng_wr_data,
  input  logic          eng_done,
  input  logic [LW-1:0] eng_done_len,
  input  logic [AW-1:0] snd_addr,
  output logic [DW-1:0] snd_data,
  input  logic          snd_release,
  output logic          is_free,
  output logic          is_busy,
  output logic          is_pend,
  output logic [LW-1:0] len,
  output logic          irq
);
  logic [DW-1:0] mem [MAX_WORDS];
  slot_state_e   st_q, st_n;
  logic [LW-1:0] len_q, len_n;
  logic          wr, irq_n;
  logic [AW-1:0] waddr;
  logic [DW-1:0] wdata;

  assign is_free     = (st_q == SLOT_FREE);
  assign is_busy     = (st_q == SLOT_WORK);
  assign is_pend     = (st_q == SLOT_SEND);
  assign len         = len_q;
  assign eng_rd_data = mem[eng_rd_addr];
  assign snd_data    = mem[snd_addr];

  always_comb begin
    wr    = 1'b0;
    waddr = fill_addr;
    wdata = fill_data;
    if (st_q == SLOT_FILL && fill_we) begin
      wr = 1'b1;
    end else if (st_q == SLOT_WORK && eng_we) begin
      wr    = 1'b1;
      waddr = eng_wr_addr;
      wdata = eng_wr_data;
    end
    st_n  = st_q;
    len_n = len_q;
    irq_n = 1'b0;
    case (st_q)
      SLOT_FREE: if (claim) st_n = SLOT_FILL;
      SLOT_FILL: if (fill_we && fill_last) begin
        st_n  = SLOT_WORK;
        len_n = LW'(fill_addr) + LW'(1);
      end
      SLOT_WORK: if (eng_done) begin
        st_n  = SLOT_SEND;
        len_n = eng_done_len;
      end
      default: if (snd_release) begin
        st_n  = SLOT_FREE;
        irq_n = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (wr) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SLOT_FREE;
      len_q <= '0;
      irq   <= 1'b0;
    end else begin
      st_q  <= st_n;
      len_q <= len_n;
      irq   <= irq_n;
    end
  end

  assert_claim_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> (st_q == SLOT_FREE));
  assert_irq_freed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (st_q == SLOT_FREE));
endmodule

// File: rtl/pkt_egress.sv
module pkt_egress #(
  parameter int DW        = 64,
  parameter int NUM_ENG   = 4,
  parameter int MAX_WORDS = 8,
  localparam int AW       = $clog2(MAX_WORDS),
  localparam int LW       = $clog2(MAX_WORDS + 1),
  localparam int IW       = $clog2(NUM_ENG)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ENG-1:0]    pend,
  input  logic [NUM_ENG*LW-1:0] len_flat,
  input  logic [NUM_ENG*DW-1:0] data_flat,
  output logic [AW-1:0]         rd_addr,
  output logic [NUM_ENG-1:0]    release_o,
  output logic                  out_valid,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [DW-1:0]         out_data
);
  logic          busy_q, busy_n, pick_any, last;
  logic [IW-1:0] cur_q, cur_n, ptr_q, ptr_n, pick_idx;
  logic [AW-1:0] cnt_q, cnt_n;
  logic [LW-1:0] cur_len;

  // rotating priority: first pending engine at or after ptr_q
  always_comb begin
    pick_any = 1'b0;
    pick_idx = '0;
    for (int off = NUM_ENG - 1; off >= 0; off--) begin
      int j;
      j = int'(ptr_q) + off;
      if (j >= NUM_ENG) j = j - NUM_ENG;
      if (pend[j]) begin
        pick_any = 1'b1;
        pick_idx = IW'(j);
      end
    end
  end

  assign cur_len   = len_flat[cur_q*LW +: LW];
  assign last      = busy_q && (LW'(cnt_q) + LW'(1) == cur_len);
  assign out_valid = busy_q;
  assign out_sop   = busy_q && (cnt_q == '0);
  assign out_eop   = last;
  assign out_data  = data_flat[cur_q*DW +: DW];
  assign rd_addr   = cnt_q;

  always_comb begin
    busy_n    = busy_q;
    cur_n     = cur_q;
    cnt_n     = cnt_q;
    ptr_n     = ptr_q;
    release_o = '0;
    if (!busy_q) begin
      if (pick_any) begin
        busy_n = 1'b1;
        cur_n  = pick_idx;
        cnt_n  = '0;
      end
    end else if (last) begin
      busy_n           = 1'b0;
      release_o[cur_q] = 1'b1;
      ptr_n            = (cur_q == IW'(NUM_ENG - 1)) ? '0 : cur_q + 1'b1;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      cnt_q  <= '0;
      ptr_q  <= '0;
    end else begin
      busy_q <= busy_n;
      cur_q  <= cur_n;
      cnt_q  <= cnt_n;
      ptr_q  <= ptr_n;
    end
  end

  assert_contiguous_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> $past(out_valid));
  assert_serve_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> pend[cur_q]);
  assert_single_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(release_o));
endmodule

// File: rtl/pkt_dispatch.sv
module pkt_dispatch #(
  parameter int DW        = 64,
  parameter int NUM_ENG   = 4,
  parameter int MAX_WORDS = 8,
  parameter int CNT_W     = 16,
  localparam int AW       = $clog2(MAX_WORDS),
  localparam int LW       = $clog2(MAX_WORDS + 1),
  localparam int IW       = $clog2(NUM_ENG),
  localparam int POOL_D   = NUM_ENG * MAX_WORDS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic                  in_sop,
  input  logic                  in_eop,
  input  logic [DW-1:0]         in_data,
  output logic [NUM_ENG-1:0]    eng_busy,
  output logic [NUM_ENG*LW-1:0] eng_len,
  input  logic [NUM_ENG*AW-1:0] eng_rd_addr,
  output logic [NUM_ENG*DW-1:0] eng_rd_data,
  input  logic [NUM_ENG-1:0]    eng_we,
  input  logic [NUM_ENG*AW-1:0] eng_wr_addr,
  input  logic [NUM_ENG*DW-1:0] eng_wr_data,
  input  logic [NUM_ENG-1:0]    eng_done,
  input  logic [NUM_ENG*LW-1:0] eng_done_len,
  output logic [NUM_ENG-1:0]    eng_irq,
  output logic                  out_valid,
  output logic                  out_sop,
  output logic                  out_eop,
  output logic [DW-1:0]         out_data,
  output logic [CNT_W-1:0]      drop_count
);
  logic [1:0]            rst_sync;
  logic                  rst_n_s;
  logic                  pop, rd_eop, pkt_avail, drop_pulse, free_any;
  logic [DW-1:0]         rd_data;
  logic                  moving, mv_n;
  logic [IW-1:0]         tgt, tgt_n, free_idx;
  logic [AW-1:0]         dcnt, dcnt_n, snd_addr;
  logic [NUM_ENG-1:0]    claim, slot_free, slot_pend, release_v;
  logic [NUM_ENG*DW-1:0] snd_flat;
  logic [CNT_W-1:0]      drop_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_s = rst_sync[1];

  pkt_pool #(.DW(DW), .DEPTH(POOL_D), .MAX_WORDS(MAX_WORDS)) u_pool (
    .clk(clk), .rst_n(rst_n_s), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .pop(pop), .rd_data(rd_data),
    .rd_eop(rd_eop), .pkt_avail(pkt_avail), .drop_pulse(drop_pulse));

  // lowest-index free engine
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NUM_ENG - 1; i >= 0; i--) begin
      if (slot_free[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  always_comb begin
    mv_n   = moving;
    tgt_n  = tgt;
    dcnt_n = dcnt;
    claim  = '0;
    pop    = 1'b0;
    if (!moving) begin
      if (pkt_avail && free_any) begin
        claim[free_idx] = 1'b1;
        mv_n            = 1'b1;
        tgt_n           = free_idx;
        dcnt_n          = '0;
      end
    end else begin
      pop = 1'b1;
      if (rd_eop) mv_n   = 1'b0;
      else        dcnt_n = dcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      moving <= 1'b0;
      tgt    <= '0;
      dcnt   <= '0;
      drop_q <= '0;
    end else begin
      moving <= mv_n;
      tgt    <= tgt_n;
      dcnt   <= dcnt_n;
      if (drop_pulse) drop_q <= drop_q + 1'b1;
    end
  end
  assign drop_count = drop_q;

  for (genvar g = 0; g < NUM_ENG; g++) begin : g_slot
    pkt_slot #(.DW(DW), .MAX_WORDS(MAX_WORDS)) u_slot (
      .clk(clk), .rst_n(rst_n_s), .claim(claim[g]),
      .fill_we(moving && (tgt == IW'(g))), .fill_addr(dcnt),
      .fill_data(rd_data), .fill_last(rd_eop),
      .eng_rd_addr(eng_rd_addr[g*AW +: AW]),
      .eng_rd_data(eng_rd_data[g*DW +: DW]),
      .eng_we(eng_we[g]), .eng_wr_addr(eng_wr_addr[g*AW +: AW]),
      .eng_wr_data(eng_wr_data[g*DW +: DW]), .eng_done(eng_done[g]),
      .eng_done_len(eng_done_len[g*LW +: LW]), .snd_addr(snd_addr),
      .snd_data(snd_flat[g*DW +: DW]), .snd_release(release_v[g]),
      .is_free(slot_free[g]), .is_busy(eng_busy[g]), .is_pend(slot_pend[g]),
      .len(eng_len[g*LW +: LW]), .irq(eng_irq[g]));
  end

  pkt_egress #(.DW(DW), .NUM_ENG(NUM_ENG), .MAX_WORDS(MAX_WORDS)) u_egress (
    .clk(clk), .rst_n(rst_n_s), .pend(slot_pend), .len_flat(eng_len),
    .data_flat(snd_flat), .rd_addr(snd_addr), .release_o(release_v),
    .out_valid(out_valid), .out_sop(out_sop), .out_eop(out_eop),
    .out_data(out_data));

  assert_one_claim_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(claim));
  assert_drop_step_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    drop_pulse |=> (drop_count == $past(drop_count) + 1'b1));
  assert_irq_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(eng_irq));
endmodule

// File: tb/pkt_dispatch_bench.sv
`timescale 1ns/1ps
module pkt_dispatch_bench;
  localparam int DW = 64, K = 4, MAXW = 8, CW = 16;
  localparam int AW = $clog2(MAXW), LW = $clog2(MAXW + 1);
  localparam logic [DW-1:0] MASK = 64'hA5A5_5A5A_0F0F_F0F0;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sop, in_eop;
  logic [DW-1:0] in_data;
  logic [K-1:0] eng_busy, eng_we, eng_done, eng_irq;
  logic [K*LW-1:0] eng_len, eng_done_len;
  logic [K*AW-1:0] eng_rd_addr, eng_wr_addr;
  logic [K*DW-1:0] eng_rd_data, eng_wr_data;
  logic out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic [CW-1:0] drop_count;

  logic [AW-1:0] b_rd [K];
  logic [AW-1:0] b_wa [K];
  logic [DW-1:0] b_wd [K];
  logic          b_we [K];
  logic          b_dn [K];
  logic [LW-1:0] b_dl [K];
  logic [K-1:0]  hold;
  bit            rand_lat;

  int checks = 0, errors = 0, out_cnt = 0;
  int out_order [512];
  logic [K-1:0] irq_log [512];
  int received [512];
  bit finished = 0;

  always #2.5 clk = ~clk;

  pkt_dispatch #(.DW(DW), .NUM_ENG(K), .MAX_WORDS(MAXW), .CNT_W(CW)) u_pkt_dispatch (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .eng_busy(eng_busy), .eng_len(eng_len),
    .eng_rd_addr(eng_rd_addr), .eng_rd_data(eng_rd_data), .eng_we(eng_we),
    .eng_wr_addr(eng_wr_addr), .eng_wr_data(eng_wr_data), .eng_done(eng_done),
    .eng_done_len(eng_done_len), .eng_irq(eng_irq), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data),
    .drop_count(drop_count));

  always_comb begin
    for (int i = 0; i < K; i++) begin
      eng_rd_addr[i*AW +: AW]  = b_rd[i];
      eng_wr_addr[i*AW +: AW]  = b_wa[i];
      eng_wr_data[i*DW +: DW]  = b_wd[i];
      eng_we[i]                = b_we[i];
      eng_done[i]              = b_dn[i];
      eng_done_len[i*LW +: LW] = b_dl[i];
    end
  end

  function automatic logic [DW-1:0] pkt_word(int seq, int len, int i);
    return {seq[31:0], len[7:0], i[23:0]};
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // engine models: read packet, write it back XORed with MASK (R6)
  for (genvar e = 0; e < K; e++) begin : g_eng
    initial begin
      b_rd[e] = '0; b_wa[e] = '0; b_wd[e] = '0; b_we[e] = 1'b0;
      b_dn[e] = 1'b0; b_dl[e] = '0;
      forever begin
        @(negedge clk);
        if (rst_n && eng_busy[e] && !hold[e]) begin
          int lat;
          int n;
          lat = rand_lat ? int'($urandom_range(0, 6)) : 2;
          n = int'(eng_len[e*LW +: LW]);
          repeat (lat) @(negedge clk);
          for (int i = 0; i < n; i++) begin
            b_rd[e] = AW'(i);
            #1;
            b_wd[e] = eng_rd_data[e*DW +: DW] ^ MASK;
            b_wa[e] = AW'(i);
            b_we[e] = 1'b1;
            @(negedge clk);
          end
          b_we[e] = 1'b0;
          b_dn[e] = 1'b1;
          b_dl[e] = LW'(n);
          @(negedge clk);
          b_dn[e] = 1'b0;
        end
      end
    end
  end

  // egress monitor: content, length, duplicates (R9), interrupt (R8)
  logic [DW-1:0] words [MAXW];
  int wi = 0;
  bit irq_due = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (irq_due) begin
        irq_log[out_cnt-1] = eng_irq;
        check($countones(eng_irq) == 1, "R8", "one irq after eop", eng_irq, 1);
        irq_due = 0;
      end
      if (out_valid) begin
        if (out_sop) wi = 0;
        if (wi < MAXW) words[wi] = out_data;
        wi++;
        if (out_eop) begin
          logic [DW-1:0] w0;
          int seq, ln;
          bit ok;
          w0 = words[0] ^ MASK;
          seq = int'(w0[63:32]);
          ln = int'(w0[31:24]);
          ok = (ln == wi) && (seq >= 0) && (seq < 512);
          for (int i = 0; i < MAXW; i++)
            if (ok && i < ln && (words[i] ^ MASK) != pkt_word(seq, ln, i)) ok = 0;
          check(ok, "R9", "result content/length", wi, ln);
          if (seq >= 0 && seq < 512) begin
            check(received[seq] == 0, "R9", "duplicate result", received[seq], 0);
            received[seq]++;
          end
          out_order[out_cnt] = seq;
          out_cnt++;
          irq_due = 1;
        end
      end
    end
  end

  task automatic send_pkt(int seq, int len, int gap);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1);
      in_data = pkt_word(seq, len, i);
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic wait_out(int n);
    int t;
    t = 0;
    while (out_cnt < n && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(out_cnt >= n, "R9", "results arrived", out_cnt, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    int d0, sent, r;
    for (int i = 0; i < 512; i++) received[i] = 0;
    rst_n = 1'b0; hold = '1; rand_lat = 0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_data = '0;
    repeat (4) @(negedge clk);
    check(eng_busy == 0 && out_valid == 0 && drop_count == 0 && eng_irq == 0,
          "R1", "reset state", {eng_busy, eng_irq, out_valid}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(eng_busy == 0 && out_valid == 0 && drop_count == 0,
          "R1", "state after release", drop_count, 0);

    // fill engines in lowest-free order
    send_pkt(0, 3, 0); repeat (12) @(negedge clk);
    check(eng_busy == 4'b0001, "R4", "first to engine 0", eng_busy, 4'b0001);
    check(eng_len[0 +: LW] == 3, "R3", "engine 0 length", eng_len[0 +: LW], 3);
    send_pkt(1, 5, 0); repeat (12) @(negedge clk);
    check(eng_busy == 4'b0011, "R4", "second to engine 1", eng_busy, 4'b0011);
    check(eng_len[LW +: LW] == 5, "R3", "engine 1 length", eng_len[LW +: LW], 5);
    send_pkt(2, 8, 0); send_pkt(3, 8, 0); repeat (14) @(negedge clk);
    check(eng_busy == 4'b1111, "R4", "all engines loaded", eng_busy, 4'b1111);

    // pool to exactly full, then one more
    for (int s = 4; s < 8; s++) send_pkt(s, 8, 1);
    repeat (4) @(negedge clk);
    check(drop_count == 0, "R2", "pool exactly full accepted", drop_count, 0);
    send_pkt(8, 1, 2);
    check(drop_count == 1, "R2", "overflow packet dropped", drop_count, 1);
    check(out_cnt == 0, "R6", "nothing out before done", out_cnt, 0);

    @(posedge clk); hold = '0;
    wait_out(8);
    for (int i = 0; i < 4; i++)
      check(out_order[i] == i, "R7", "first round order", out_order[i], i);
    for (int i = 4; i < 8; i++)
      check(out_order[i] == i, "R5", "refill in arrival order", out_order[i], i);
    check(irq_log[0] == 4'b0001, "R8", "irq of engine 0", irq_log[0], 4'b0001);
    check(irq_log[1] == 4'b0010, "R8", "irq of engine 1", irq_log[1], 4'b0010);
    repeat (20) @(negedge clk);
    check(received[8] == 0, "R2", "dropped packet absent", received[8], 0);
    check(eng_busy == 0, "R6", "busy cleared after done", eng_busy, 0);

    // rotating egress: serve engine 2 alone, then 3,0,1 together
    @(posedge clk); hold = '1;
    for (int s = 20; s < 24; s++) send_pkt(s, 4, 1);
    repeat (20) @(negedge clk);
    check(eng_busy == 4'b1111, "R4", "second load all engines", eng_busy, 4'b1111);
    @(posedge clk); hold = 4'b1011;
    wait_out(9);
    check(out_order[8] == 22, "R7", "lone engine 2", out_order[8], 22);
    repeat (4) @(negedge clk);
    @(posedge clk); hold = '0;
    wait_out(12);
    check(out_order[9] == 23, "R7", "after 2 comes 3", out_order[9], 23);
    check(out_order[10] == 20, "R7", "wrap to 0", out_order[10], 20);
    check(out_order[11] == 21, "R7", "then 1", out_order[11], 21);

    // constrained random traffic
    r = int'($urandom(32'd4242));
    rand_lat = 1;
    d0 = int'(drop_count);
    sent = 0;
    for (int s = 100; s < 300; s++) begin
      send_pkt(s, int'($urandom_range(1, MAXW)), int'($urandom_range(0, 3)));
      sent++;
    end
    begin
      int t;
      t = 0;
      while ((out_cnt - 12) + (int'(drop_count) - d0) < sent && t < 20000) begin
        @(negedge clk);
        t++;
      end
    end
    repeat (10) @(negedge clk);
    begin
      int got;
      got = 0;
      for (int s = 100; s < 300; s++) got += received[s];
      check(got + (int'(drop_count) - d0) == sent, "R9", "accepted plus dropped",
            got + int'(drop_count) - d0, sent);
      check(out_cnt - 12 == got, "R9", "no stray results", out_cnt - 12, got);
    end
    check(eng_busy == 0, "R6", "engines idle at end", eng_busy, 0);
    finish_run();
  end
endmodule